// File: doc/BRIEF.md
# Two-Bank SDRAM Command Sequencer

This block sits on the controller side of a synchronous DRAM with two banks. It accepts one access request at a time over a valid/ready handshake. A request names a bank, a row, a column, the direction (read or write) and whether the bank should close itself when the burst ends. From these, the block produces the device command stream: row open, column read, column write, bank close, or no-operation. It also produces a write-data enable and a read-capture strobe that line up with the four-beat data bursts.

The sequencer records whether each bank is closed, open (with the open row) or closing. It handles a row miss by closing the bank and then reopening it at the new row. Three delays are run-time inputs counted in clock cycles: the read latency (1 to 3), the recovery time after the last write beat, and the close-to-open delay. Each bank has its own down-counter, so one bank can close while the other keeps serving column commands. A burst that closes its bank by itself cannot be cut short. Other bursts may be followed on the next cycle by a column command of the same direction.

Top module: `dbk_sched`

## Requirements
- R1: While reset is high and in the first cycle after it, the command output is NOP (code 0), both data strobes are low and ready is low. Both banks start closed.
- R2: Command codes are NOP=0, open-row=1, read=2, write=3, close=4. An open-row command carries the row on the address output. A read or write carries the zero-extended column and the request's self-close flag. Ready is high only in the cycle whose request appears as a read or write on the next cycle.
- R3: A request to a closed bank produces an open-row command. The column command follows on the very next cycle.
- R4: After a close command to a bank, the open-row command to that bank comes exactly close-to-open cycles later when a request is waiting for it.
- R5: On a row miss after a write, the close command comes exactly 3 + recovery cycles after the write command, so the recovery time is counted from the fourth data beat.
- R6: On a row miss after a read, the close command comes exactly 4 cycles after the read command. The read data still to arrive is the latency minus one beats.
- R7: After a self-closing read, the next open-row command to that bank comes exactly 4 + close-to-open cycles after the read. After a self-closing write, it comes 3 + recovery + close-to-open cycles after the write.
- R8: After a self-closing burst, no read or write to either bank is issued for 3 cycles. After a burst that does not close its bank, a column command of the same direction may follow on the next cycle.
- R9: A write that follows a read waits at least latency + 4 cycles. A read that follows a write waits at least 4 cycles.
- R10: The read-capture strobe rises exactly latency cycles after a read command and stays high for 4 cycles. A back-to-back read extends it.
- R11: The write-data enable is high in the cycle of a write command and the three cycles after it.
- R12: While one bank is closing, a read or write to the other, open bank is issued as soon as the column spacing allows.
- R13: With no request, or with a request that no command can yet serve, the command output is NOP and ready stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_cl | input | 2 | Read latency in cycles (1 to 3) |
| cfg_trdl | input | CNT_W | Write recovery cycles before a close |
| cfg_trp | input | CNT_W | Close-to-open cycles |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_bank | input | 1 | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Target column |
| req_write | input | 1 | 1 = write, 0 = read |
| req_ap | input | 1 | Close the bank when the burst ends |
| cmd_o | output | 3 | Command code |
| cmd_bank_o | output | 1 | Bank addressed by the command |
| cmd_addr_o | output | ROW_W | Row or column address |
| cmd_ap_o | output | 1 | Self-close flag of a read or write |
| wdata_en_o | output | 1 | Write data beat enable |
| rdata_cap_o | output | 1 | Read data capture strobe |

## Verification
Every command appears on the command output one cycle after the request state that allows it. The bench therefore logs the cycle number of each non-NOP command, sampled on the falling clock edge, and checks the distances between logged commands against the expected counts. Examples are 3 + recovery from write to close, close-to-open from close to open-row, and latency + 4 from read to write. The strobes are logged the same way: the first cycle and the number of high cycles of the read-capture strobe are compared with read cycle + latency and with 4 (or 5 for two back-to-back reads). Each scenario leaves enough idle cycles that every counter has expired before the next scenario starts.

// File: rtl/dbk_pkg.sv
`timescale 1ns/1ps
package dbk_pkg;

    localparam int NUM_BANKS = 2;
    localparam int BANK_W    = 1;
    localparam int BURST_LEN = 4;
    localparam int MAX_CL    = 3;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4
    } cmd_e;

    typedef enum logic [1:0] {
        BK_IDLE    = 2'd0,
        BK_OPEN    = 2'd1,
        BK_CLOSING = 2'd2
    } bank_st_e;

    typedef struct packed {
        cmd_e              op;
        logic [BANK_W-1:0] bank;
        logic              ap;
    } cmd_t;

    // read latency of 0 is treated as 1
    function automatic logic [1:0] eff_cl(input logic [1:0] cl);
        return (cl == 2'd0) ? 2'd1 : cl;
    endfunction

endpackage

// File: rtl/dbk_bank_track.sv
`timescale 1ns/1ps
module dbk_bank_track import dbk_pkg::*; #(
    parameter int ROW_W = 11,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cfg_trdl,
    input  logic [CNT_W-1:0] cfg_trp,
    input  logic             ev_act,
    input  logic             ev_pre,
    input  logic             ev_rd,
    input  logic             ev_wr,
    input  logic             ev_ap,
    input  logic [ROW_W-1:0] ev_row,
    output bank_st_e         st_o,
    output logic [ROW_W-1:0] row_o,
    output logic             ok_o
);
    localparam int TW = CNT_W + 2;

    bank_st_e         st;
    logic [ROW_W-1:0] row;
    logic [TW-1:0]    tmr, tmr_dec, trdl_x, trp_x, close_gap, col_gap, col_val;

    assign trdl_x    = TW'(cfg_trdl);
    assign trp_x     = TW'(cfg_trp);
    assign tmr_dec   = (tmr == '0) ? '0 : tmr - 1'b1;
    assign close_gap = (trp_x == '0) ? '0 : trp_x - 1'b1;

    // wait, counted from the column command, until the bank may close (or reopen)
    always_comb begin
        col_gap = ev_wr ? (TW'(BURST_LEN - 2) + trdl_x) : TW'(BURST_LEN - 1);
        if (ev_ap)
            col_gap = col_gap + trp_x;
        col_val = (col_gap > tmr_dec) ? col_gap : tmr_dec;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= BK_IDLE;
            row <= '0;
            tmr <= '0;
        end else if (ev_act) begin
            st  <= BK_OPEN;
            row <= ev_row;
            tmr <= '0;
        end else if (ev_pre) begin
            st  <= BK_CLOSING;
            tmr <= close_gap;
        end else if (ev_rd || ev_wr) begin
            tmr <= col_val;
            if (ev_ap)
                st <= BK_CLOSING;
        end else begin
            tmr <= tmr_dec;
            if (st == BK_CLOSING && tmr == '0)
                st <= BK_IDLE;
        end
    end

    assign st_o  = st;
    assign row_o = row;
    assign ok_o  = (tmr == '0);

endmodule

// File: rtl/dbk_issue.sv
`timescale 1ns/1ps
module dbk_issue import dbk_pkg::*; #(
    parameter int ROW_W = 11,
    parameter int COL_W = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [1:0]           cfg_cl,
    input  logic                 req_valid,
    input  logic [BANK_W-1:0]    req_bank,
    input  logic [ROW_W-1:0]     req_row,
    input  logic [COL_W-1:0]     req_col,
    input  logic                 req_write,
    input  logic                 req_ap,
    input  bank_st_e             bank_st  [NUM_BANKS],
    input  logic [ROW_W-1:0]     open_row [NUM_BANKS],
    input  logic [NUM_BANKS-1:0] bank_ok,
    output cmd_t                 nxt,
    output logic [ROW_W-1:0]     nxt_addr,
    output logic                 req_ready
);
    localparam logic [2:0] SPAN = 3'(BURST_LEN - 1);

    logic [2:0] rd_blk, wr_blk, rd_dec, wr_dec, rw_gap;
    logic       col_ok;

    assign rd_dec = (rd_blk == '0) ? '0 : rd_blk - 1'b1;
    assign wr_dec = (wr_blk == '0) ? '0 : wr_blk - 1'b1;
    assign rw_gap = 3'(eff_cl(cfg_cl)) + SPAN;
    assign col_ok = req_write ? (wr_blk == '0) : (rd_blk == '0);

    always_comb begin
        nxt.op    = CMD_NOP;
        nxt.bank  = req_bank;
        nxt.ap    = 1'b0;
        nxt_addr  = '0;
        req_ready = 1'b0;
        if (req_valid) begin
            unique case (bank_st[req_bank])
                BK_IDLE: begin
                    nxt.op   = CMD_ACT;
                    nxt_addr = req_row;
                end
                BK_CLOSING: begin
                    if (bank_ok[req_bank]) begin
                        nxt.op   = CMD_ACT;
                        nxt_addr = req_row;
                    end
                end
                BK_OPEN: begin
                    if (open_row[req_bank] == req_row) begin
                        if (col_ok) begin
                            nxt.op    = req_write ? CMD_WR : CMD_RD;
                            nxt.ap    = req_ap;
                            nxt_addr  = ROW_W'(req_col);
                            req_ready = 1'b1;
                        end
                    end else if (bank_ok[req_bank]) begin
                        nxt.op = CMD_PRE;
                    end
                end
                default: ;
            endcase
        end
    end

    // column spacing shared by both banks
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_blk <= '0;
            wr_blk <= '0;
        end else if (nxt.op == CMD_RD) begin
            rd_blk <= nxt.ap ? SPAN : 3'd0;
            wr_blk <= (rw_gap > wr_dec) ? rw_gap : wr_dec;
        end else if (nxt.op == CMD_WR) begin
            wr_blk <= nxt.ap ? SPAN : 3'd0;
            rd_blk <= (SPAN > rd_dec) ? SPAN : rd_dec;
        end else begin
            rd_blk <= rd_dec;
            wr_blk <= wr_dec;
        end
    end

endmodule

// File: rtl/dbk_strobes.sv
`timescale 1ns/1ps
module dbk_strobes import dbk_pkg::*; (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] cfg_cl,
    input  logic       rd_fire,
    input  logic       wr_fire,
    output logic       wdata_en_o,
    output logic       rdata_cap_o
);
    logic [MAX_CL-1:0] rd_pipe;
    logic [2:0]        rcnt, wcnt;
    logic [1:0]        tap;
    logic              cap_start;

    assign tap       = eff_cl(cfg_cl) - 2'd1;
    assign cap_start = rd_pipe[tap];

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_pipe <= '0;
            rcnt    <= '0;
            wcnt    <= '0;
        end else begin
            rd_pipe <= {rd_pipe[MAX_CL-2:0], rd_fire};
            if (cap_start)
                rcnt <= 3'(BURST_LEN);
            else if (rcnt != '0)
                rcnt <= rcnt - 1'b1;
            if (wr_fire)
                wcnt <= 3'(BURST_LEN);
            else if (wcnt != '0)
                wcnt <= wcnt - 1'b1;
        end
    end

    assign rdata_cap_o = (rcnt != '0);
    assign wdata_en_o  = (wcnt != '0);

endmodule

// File: rtl/dbk_sched.sv
`timescale 1ns/1ps
module dbk_sched import dbk_pkg::*; #(
    parameter int ROW_W = 11,
    parameter int COL_W = 8,
    parameter int CNT_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        cfg_cl,
    input  logic [CNT_W-1:0]  cfg_trdl,
    input  logic [CNT_W-1:0]  cfg_trp,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic              req_write,
    input  logic              req_ap,
    output logic [2:0]        cmd_o,
    output logic [BANK_W-1:0] cmd_bank_o,
    output logic [ROW_W-1:0]  cmd_addr_o,
    output logic              cmd_ap_o,
    output logic              wdata_en_o,
    output logic              rdata_cap_o
);
    cmd_t                 nxt;
    logic [ROW_W-1:0]     nxt_addr;
    bank_st_e             bank_st  [NUM_BANKS];
    logic [ROW_W-1:0]     open_row [NUM_BANKS];
    logic [NUM_BANKS-1:0] bank_ok;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic sel;
        assign sel = (nxt.bank == BANK_W'(b));
        dbk_bank_track #(.ROW_W(ROW_W), .CNT_W(CNT_W)) u_trk (
            .clk      (clk),
            .rst      (rst),
            .cfg_trdl (cfg_trdl),
            .cfg_trp  (cfg_trp),
            .ev_act   (sel && nxt.op == CMD_ACT),
            .ev_pre   (sel && nxt.op == CMD_PRE),
            .ev_rd    (sel && nxt.op == CMD_RD),
            .ev_wr    (sel && nxt.op == CMD_WR),
            .ev_ap    (nxt.ap),
            .ev_row   (nxt_addr),
            .st_o     (bank_st[b]),
            .row_o    (open_row[b]),
            .ok_o     (bank_ok[b])
        );
    end

    dbk_issue #(.ROW_W(ROW_W), .COL_W(COL_W)) u_issue (
        .clk       (clk),
        .rst       (rst),
        .cfg_cl    (cfg_cl),
        .req_valid (req_valid),
        .req_bank  (req_bank),
        .req_row   (req_row),
        .req_col   (req_col),
        .req_write (req_write),
        .req_ap    (req_ap),
        .bank_st   (bank_st),
        .open_row  (open_row),
        .bank_ok   (bank_ok),
        .nxt       (nxt),
        .nxt_addr  (nxt_addr),
        .req_ready (req_ready)
    );

    dbk_strobes u_strb (
        .clk         (clk),
        .rst         (rst),
        .cfg_cl      (cfg_cl),
        .rd_fire     (nxt.op == CMD_RD),
        .wr_fire     (nxt.op == CMD_WR),
        .wdata_en_o  (wdata_en_o),
        .rdata_cap_o (rdata_cap_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_o      <= CMD_NOP;
            cmd_bank_o <= '0;
            cmd_addr_o <= '0;
            cmd_ap_o   <= 1'b0;
        end else begin
            cmd_o      <= nxt.op;
            cmd_bank_o <= nxt.bank;
            cmd_addr_o <= nxt_addr;
            cmd_ap_o   <= nxt.ap;
        end
    end

endmodule

// File: rtl/dbk_sched_chk.sv
`timescale 1ns/1ps
module dbk_sched_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] cfg_cl,
    input logic       req_valid,
    input logic       req_ready,
    input logic [2:0] cmd_o,
    input logic       cmd_bank_o,
    input logic       cmd_ap_o,
    input logic       wdata_en_o,
    input logic       rdata_cap_o
);
    assert_ready_gives_column_R2: assert property (@(posedge clk) disable iff (rst)
        req_ready |=> (cmd_o == 3'd2 || cmd_o == 3'd3));

    assert_ready_needs_valid_R13: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> req_valid);

    assert_nop_without_request_R13: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (cmd_o == 3'd0));

    assert_wen_with_write_R11: assert property (@(posedge clk) disable iff (rst)
        (cmd_o == 3'd3) |-> wdata_en_o);

    assert_selfclose_uncut_R8: assert property (@(posedge clk) disable iff (rst)
        ((cmd_o == 3'd2 || cmd_o == 3'd3) && cmd_ap_o) |=> !(cmd_o == 3'd2 || cmd_o == 3'd3));

    assert_cl1_capture_R10: assert property (@(posedge clk) disable iff (rst)
        (cmd_o == 3'd2 && cfg_cl == 2'd1) |=> rdata_cap_o);

    assert_no_close_after_read_R6: assert property (@(posedge clk) disable iff (rst)
        (cmd_o == 3'd2) |=> !(cmd_o == 3'd4 && cmd_bank_o == $past(cmd_bank_o)));

endmodule

bind dbk_sched dbk_sched_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_cl      (cfg_cl),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .cmd_o       (cmd_o),
    .cmd_bank_o  (cmd_bank_o),
    .cmd_ap_o    (cmd_ap_o),
    .wdata_en_o  (wdata_en_o),
    .rdata_cap_o (rdata_cap_o)
);

// File: tb/sim_dbk_sched.sv
`timescale 1ns/1ps
module sim_dbk_sched;
    localparam int ROW_W = 11;
    localparam int COL_W = 8;
    localparam int CNT_W = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [1:0]       cfg_cl = 2'd2;
    logic [CNT_W-1:0] cfg_trdl = 4'd2;
    logic [CNT_W-1:0] cfg_trp = 4'd3;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic             req_bank = 1'b0;
    logic [ROW_W-1:0] req_row = '0;
    logic [COL_W-1:0] req_col = '0;
    logic             req_write = 1'b0;
    logic             req_ap = 1'b0;
    logic [2:0]       cmd_o;
    logic             cmd_bank_o;
    logic [ROW_W-1:0] cmd_addr_o;
    logic             cmd_ap_o;
    logic             wdata_en_o;
    logic             rdata_cap_o;

    always #2 clk = ~clk;

    dbk_sched #(.ROW_W(ROW_W), .COL_W(COL_W), .CNT_W(CNT_W)) u0 (.*);

    int nchk = 0, nerr = 0, cyc = 0;
    logic [2:0] lop  [64];
    int         lbk  [64];
    int         ladr [64];
    int         lap  [64];
    int         lcy  [64];
    int         ln = 0;
    int         rfirst = -1, rcnt = 0, wfirst = -1, wcnt = 0;

    always @(negedge clk) begin
        cyc++;
        if (cmd_o != 3'd0 && ln < 64) begin
            lop[ln] = cmd_o; lbk[ln] = int'(cmd_bank_o);
            ladr[ln] = int'(cmd_addr_o); lap[ln] = int'(cmd_ap_o); lcy[ln] = cyc;
            ln++;
        end
        if (rdata_cap_o) begin if (rcnt == 0) rfirst = cyc; rcnt++; end
        if (wdata_en_o)  begin if (wcnt == 0) wfirst = cyc; wcnt++; end
    end

    task automatic chk(input string rq, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    task automatic clr();
        ln = 0; rfirst = -1; rcnt = 0; wfirst = -1; wcnt = 0;
    endtask

    function automatic int find(input logic [2:0] op, input int bk, input int nth);
        int n = 0;
        for (int i = 0; i < ln; i++)
            if (lop[i] == op && lbk[i] == bk) begin
                if (n == nth) return i;
                n++;
            end
        return -1;
    endfunction

    function automatic int at(input logic [2:0] op, input int bk, input int nth);
        int i = find(op, bk, nth);
        return (i < 0) ? -1 : lcy[i];
    endfunction

    task automatic send(input int bk, input int row, input int col, input bit wr, input bit ap);
        @(negedge clk);
        req_valid = 1'b1; req_bank = bk[0]; req_row = ROW_W'(row);
        req_col = COL_W'(col); req_write = wr; req_ap = ap;
        #1;
        while (!req_ready) begin @(negedge clk); #1; end
        @(posedge clk);
    endtask

    task automatic finish_reqs();
        @(negedge clk);
        req_valid = 1'b0;
        repeat (14) @(posedge clk);
    endtask

    task automatic set_cfg(input int cl, input int trdl, input int trp);
        cfg_cl = 2'(cl); cfg_trdl = CNT_W'(trdl); cfg_trp = CNT_W'(trp);
        repeat (2) @(posedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 cmd in reset", int'(cmd_o), 0);
        chk("R1 strobes in reset", int'(wdata_en_o) + int'(rdata_cap_o), 0);
        @(posedge clk); @(negedge clk); rst = 1'b0;
        @(negedge clk); #1;
        chk("R1 cmd after reset", int'(cmd_o), 0);
        chk("R1 ready after reset", int'(req_ready), 0);
        @(posedge clk);
    endtask

    task automatic t_first_read();
        int a, r;
        clr();
        send(0, 5, 1, 0, 0);
        finish_reqs();
        a = at(3'd1, 0, 0); r = at(3'd2, 0, 0);
        chk("R3 column after open", r, a + 1);
        chk("R2 open-row address", (find(3'd1, 0, 0) < 0) ? -1 : ladr[find(3'd1, 0, 0)], 5);
        chk("R2 read column address", (find(3'd2, 0, 0) < 0) ? -1 : ladr[find(3'd2, 0, 0)], 1);
        chk("R10 capture start cl2", rfirst, r + 2);
        chk("R10 capture length", rcnt, 4);
    endtask

    task automatic t_latency(input int cl);
        int r;
        set_cfg(cl, 2, 3);
        clr();
        send(0, 5, 2, 0, 0);
        finish_reqs();
        r = at(3'd2, 0, 0);
        chk("R3 open-row hit sends no open", find(3'd1, 0, 0), -1);
        chk("R10 capture start", rfirst, r + cl);
        chk("R10 capture length", rcnt, 4);
    endtask

    task automatic t_writes();
        int w1, w2;
        set_cfg(2, 2, 3);
        clr();
        send(0, 5, 3, 1, 0);
        finish_reqs();
        w1 = at(3'd3, 0, 0);
        chk("R11 wen starts with write", wfirst, w1);
        chk("R11 wen length", wcnt, 4);
        clr();
        send(0, 5, 3, 1, 0);
        send(0, 5, 4, 1, 0);
        finish_reqs();
        w1 = at(3'd3, 0, 0); w2 = at(3'd3, 0, 1);
        chk("R8 write follows write next cycle", w2, w1 + 1);
        chk("R11 wen spans both writes", wcnt, 5);
    endtask

    task automatic t_write_miss();
        int w, p, a, r;
        clr();
        send(0, 5, 4, 1, 0);
        send(0, 9, 0, 0, 0);
        finish_reqs();
        w = at(3'd3, 0, 0); p = at(3'd4, 0, 0); a = at(3'd1, 0, 0); r = at(3'd2, 0, 0);
        chk("R5 close after write recovery", p, w + 3 + 2);
        chk("R4 open after close delay", a, p + 3);
        chk("R3 read after reopen", r, a + 1);
        chk("R13 only four commands", ln, 4);
    endtask

    task automatic t_read_miss();
        int r, p, a;
        set_cfg(2, 3, 2);
        clr();
        send(0, 9, 1, 0, 0);
        send(0, 3, 0, 0, 0);
        finish_reqs();
        r = at(3'd2, 0, 0); p = at(3'd4, 0, 0); a = at(3'd1, 0, 0);
        chk("R6 close four cycles after read", p, r + 4);
        chk("R4 open after close delay trp2", a, p + 2);
        chk("R3 read after reopen", at(3'd2, 0, 1), a + 1);
    endtask

    task automatic t_selfclose_read();
        int r0, r1, a;
        set_cfg(2, 2, 3);
        clr();
        send(1, 7, 0, 0, 0);
        finish_reqs();
        clr();
        send(0, 3, 5, 0, 1);
        send(1, 7, 1, 0, 0);
        send(0, 3, 6, 0, 0);
        finish_reqs();
        r0 = at(3'd2, 0, 0); r1 = at(3'd2, 1, 0); a = at(3'd1, 0, 0);
        chk("R2 self-close flag on read", (find(3'd2, 0, 0) < 0) ? -1 : lap[find(3'd2, 0, 0)], 1);
        chk("R8 other bank waits out self-close burst", r1, r0 + 4);
        chk("R7 reopen after self-close read", a, r0 + 4 + 3);
        chk("R12 other bank served while closing", int'(r1 < a), 1);
        chk("R3 read after reopen", at(3'd2, 0, 1), a + 1);
    endtask

    task automatic t_interrupt();
        int r1, r0;
        clr();
        send(1, 7, 2, 0, 0);
        send(0, 3, 1, 0, 0);
        finish_reqs();
        r1 = at(3'd2, 1, 0); r0 = at(3'd2, 0, 0);
        chk("R8 read follows plain read next cycle", r0, r1 + 1);
        chk("R10 capture start back-to-back", rfirst, r1 + 2);
        chk("R10 capture extended", rcnt, 5);
    endtask

    task automatic t_selfclose_write();
        int w, a;
        clr();
        send(0, 3, 0, 1, 1);
        send(0, 3, 1, 0, 0);
        finish_reqs();
        w = at(3'd3, 0, 0); a = at(3'd1, 0, 0);
        chk("R7 reopen after self-close write", a, w + 3 + 2 + 3);
        chk("R11 wen length self-close", wcnt, 4);
        chk("R3 read after reopen", at(3'd2, 0, 0), a + 1);
    endtask

    task automatic t_turnaround();
        int r, w;
        set_cfg(3, 2, 3);
        clr();
        send(1, 7, 0, 0, 0);
        send(1, 7, 1, 1, 0);
        send(1, 7, 2, 0, 0);
        finish_reqs();
        r = at(3'd2, 1, 0); w = at(3'd3, 1, 0);
        chk("R9 write after read cl3", w, r + 3 + 4);
        chk("R9 read after write", at(3'd2, 1, 1), w + 4);
    endtask

    task automatic t_quiet();
        clr();
        repeat (10) @(posedge clk);
        chk("R13 no command without request", ln, 0);
        chk("R13 no strobes without request", rcnt + wcnt, 0);
    endtask

    initial begin
        t_reset();
        t_first_read();
        t_latency(3);
        t_latency(1);
        t_writes();
        t_write_miss();
        t_read_miss();
        t_selfclose_read();
        t_interrupt();
        t_selfclose_write();
        t_turnaround();
        t_quiet();
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL R13 watchdog: actual 0 expected 1 (run completes)");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule